// File: doc/BRIEF.md
# Fractional Audio Sample Strobe Generator

The block turns one of two master-rate pulse trains into a slower sample strobe. The first train is the 44.1 kHz family and the second is the 48 kHz family. Each channel has an error accumulator in Bresenham style. On every pulse of its chosen master, the accumulator grows by a programmed increment. When the sum reaches a programmed modulus, the modulus is taken off and the channel emits a one-cycle strobe. Over time the strobe rate is master * inc / mod.

Software sets the rate with two registers per channel:

- A select register. Its bit 0 picks the master.
- A packed rate register. It holds the increment and a two's-complement modulus term.

The usual setting is inc = 4 and mod = 4 * master / rate, which covers rates from 8000 Hz to 48000 Hz. The default build has two channels, one for playback and one for record. Each channel has its own registers and its own accumulator.

Top module: `bres_sample_clk`

## Requirements
- R1: After reset every channel has select = 0, inc = 0 and an accumulator of 0. tick_o stays 0 during reset and after it, until a nonzero increment is programmed.
- R2: A write with wr_reg_i = 0 stores the select value. Bit 0 = 1 chooses m441_en_i and bit 0 = 0 chooses m48_en_i. Data bits 31:1 have no effect.
- R3: A write with wr_reg_i = 1 stores inc from data bits 15:0 and the term n from bits 31:16. The channel then uses mod = (inc - n - 1) mod 65536.
- R4: On a cycle where the chosen master pulse is high and no write targets the channel, the sum acc + inc is formed. If the sum is at least mod, acc becomes sum - mod and tick_o for that channel is 1 in the following cycle. Otherwise acc becomes the sum and tick_o is 0.
- R5: Starting from a cleared accumulator with inc <= mod, exactly inc strobes appear over mod pulses of the chosen master.
- R6: Any write to a channel clears its accumulator. The channel's tick_o is 0 in the next cycle, and a master pulse in the write cycle is dropped.
- R7: Pulses of the master that is not chosen leave the channel's accumulator and tick_o unchanged (tick_o stays 0).
- R8: A write whose wr_ch_i names one channel has no effect on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m441_en_i | input | 1 | One-cycle pulse at the 44.1 kHz-family master rate |
| m48_en_i | input | 1 | One-cycle pulse at the 48 kHz-family master rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | CH_W | Channel addressed by the write |
| wr_reg_i | input | 1 | 0 = select register, 1 = rate register |
| wr_data_i | input | 32 | Write data |
| tick_o | output | NUM_CH | One-cycle sample strobe per channel |

## Verification
- **Pseudo-random pulses.** Both masters are driven with pseudo-random pulses while the two channels run at different ratios (4/11 on the 44.1 kHz side, 4/24 on the 48 kHz side). This separates a correct per-channel master choice and remainder carry from a design that mixes up sources or channels.
- **Ratio 4/4.** A strobe is expected on every pulse. This exposes a strict-greater compare where greater-or-equal is needed.
- **Modulus that wraps.** A packed term whose modulus wraps to 65535 exposes a wrong decode of the upper halfword.
- **Writes against pulses.** Writes that coincide with pulses, and writes to the other channel, separate the clear-on-write rule from channel isolation.
- **Pulse count.** A count of strobes over exactly mod pulses confirms the average rate.

// File: rtl/bres_pkg.sv
`timescale 1ns/1ps
package bres_pkg;
  localparam int unsigned HALF_W = 16;

  typedef enum logic {
    REG_SEL  = 1'b0,
    REG_RATE = 1'b1
  } bres_reg_e;

  typedef struct packed {
    logic [HALF_W-1:0] neg_term;
    logic [HALF_W-1:0] inc;
  } rate_word_t;
endpackage

// File: rtl/bres_ch_regs.sv
`timescale 1ns/1ps
module bres_ch_regs
  import bres_pkg::*;
#(
  parameter int unsigned W = HALF_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic           reg_i,
  input  logic [2*W-1:0] data_i,
  output logic           sel_o,
  output logic [W-1:0]   inc_o,
  output logic [W-1:0]   mod_o,
  output logic           clr_o
);
  logic         sel_q;
  logic [W-1:0] inc_q, neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      inc_q <= '0;
      neg_q <= '0;
    end else if (we_i) begin
      if (reg_i == REG_SEL) begin
        sel_q <= data_i[0];
      end else begin
        inc_q <= data_i[W-1:0];
        neg_q <= data_i[2*W-1:W];
      end
    end
  end

  // upper half carries inc - mod - 1, so mod = inc - n - 1
  assign mod_o = inc_q - neg_q - W'(1);
  assign inc_o = inc_q;
  assign sel_o = sel_q;
  assign clr_o = we_i;

  assert_sel_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && reg_i == REG_SEL) |-> sel_o == $past(data_i[0]));
endmodule

// File: rtl/bres_accum.sv
`timescale 1ns/1ps
module bres_accum #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] mod_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum, diff;
  logic         hit;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, inc_i};
    diff = sum - {1'b0, mod_i};
    hit  = sum >= {1'b0, mod_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (en_i) begin
      acc_q  <= hit ? diff[W-1:0] : sum[W-1:0];
      tick_o <= hit;
    end else begin
      tick_o <= 1'b0;
    end
  end

  assert_tick_needs_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ($past(en_i) && !$past(clr_i)));
  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (acc_q == '0 && !tick_o));
  assert_idle_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(clr_i)) |-> ($stable(acc_q) && !tick_o));
endmodule

// File: rtl/bres_sample_clk.sv
`timescale 1ns/1ps
module bres_sample_clk
  import bres_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned W      = HALF_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m441_en_i,
  input  logic              m48_en_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic              wr_reg_i,
  input  logic [2*W-1:0]    wr_data_i,
  output logic [NUM_CH-1:0] tick_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic         we, sel, clr, en;
    logic [W-1:0] inc, modv;

    assign we = wr_en_i && (wr_ch_i == CH_W'(g));
    assign en = sel ? m441_en_i : m48_en_i;

    bres_ch_regs #(.W(W)) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .reg_i  (wr_reg_i),
      .data_i (wr_data_i),
      .sel_o  (sel),
      .inc_o  (inc),
      .mod_o  (modv),
      .clr_o  (clr)
    );

    bres_accum #(.W(W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en),
      .clr_i  (clr),
      .inc_i  (inc),
      .mod_i  (modv),
      .tick_o (tick_o[g])
    );
  end
endmodule

// File: tb/bres_sample_clk_test.sv
`timescale 1ns/1ps
module bres_sample_clk_test;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m441 = 1'b0, m48 = 1'b0, we = 1'b0, rg = 1'b0;
  logic [0:0]  ch = '0;
  logic [31:0] wd = '0;
  logic [NCH-1:0] tick;

  always #5 clk = ~clk;

  bres_sample_clk #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .m441_en_i(m441), .m48_en_i(m48),
    .wr_en_i(we), .wr_ch_i(ch), .wr_reg_i(rg), .wr_data_i(wd), .tick_o(tick)
  );

  typedef struct { logic [NCH-1:0] exp; string tag; } item_t;
  item_t q[$];

  int checks = 0, errors = 0, tick0_cnt = 0;
  int m_sel[NCH], m_inc[NCH], m_mod[NCH], m_acc[NCH];
  logic [15:0] lfsr = 16'hACE1;

  // monitor: compare one expected item per cycle
  always @(posedge clk) begin
    #2;
    tick0_cnt = tick0_cnt + int'(tick[0]);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (tick !== it.exp) begin
        errors++;
        $display("FAIL %s: tick_o=%b expected=%b", it.tag, tick, it.exp);
      end
    end
  end

  task automatic step(input bit e441, input bit e48, input bit w, input bit c,
                      input bit r, input logic [31:0] d, input string tag);
    item_t it;
    @(negedge clk);
    m441 = e441; m48 = e48; we = w; ch = c; rg = r; wd = d;
    for (int k = 0; k < NCH; k++) begin
      it.exp[k] = 1'b0;
      if (w && c == k[0]) begin
        m_acc[k] = 0;
        if (!r) m_sel[k] = int'(d[0]);
        else begin
          m_inc[k] = int'(d[15:0]);
          m_mod[k] = (int'(d[15:0]) - int'(d[31:16]) - 1) & 16'hFFFF;
        end
      end else if (m_sel[k] != 0 ? e441 : e48) begin
        int s;
        s = m_acc[k] + m_inc[k];
        if (s >= m_mod[k]) begin m_acc[k] = s - m_mod[k]; it.exp[k] = 1'b1; end
        else m_acc[k] = s;
      end
    end
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic set_rate(input bit c, input int inc, input int md, input string tag);
    logic [15:0] n;
    n = 16'((inc - md - 1) & 16'hFFFF);
    step(0, 0, 1, c, 1, {n, 16'(inc)}, tag);
  endtask

  task automatic pulses(input int n, input int mode, input string tag);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: step(lfsr[0], lfsr[3], 0, 0, 0, 0, tag);
        1: step(1, 0, 0, 0, 0, 0, tag);
        2: step(0, 1, 0, 0, 0, 0, tag);
        default: step(0, 0, 0, 0, 0, 0, tag);
      endcase
    end
  endtask

  task automatic drain;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin
      m_sel[k] = 0; m_inc[k] = 0; m_mod[k] = 16'hFFFF; m_acc[k] = 0;
    end
    m441 = 1; m48 = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (tick !== '0) begin
      errors++;
      $display("FAIL R1: tick_o=%b during reset, expected=00", tick);
    end
    @(negedge clk); rst_n = 1'b1;
    pulses(6, 0, "R1 idle after reset");

    // R2 / R3: ch0 on 44.1k at 4/11, ch1 on 48k at 4/24
    step(0, 0, 1, 0, 0, 32'h0000_0001, "R2 select ch0");
    step(0, 0, 1, 1, 0, 32'h0000_0000, "R2 select ch1");
    set_rate(0, 4, 11, "R3 rate ch0");
    set_rate(1, 4, 24, "R3 rate ch1");
    pulses(80, 0, "R4 mixed pulses");

    // R4 boundary: sum equals mod every pulse
    set_rate(0, 4, 4, "R4 equal ratio");
    pulses(8, 1, "R4 equal ratio");

    // R7: only unselected master pulses on ch0
    set_rate(0, 4, 11, "R7 setup");
    pulses(12, 2, "R7 unselected master");

    // R6: write coincident with pulse is dropped; R8: other channel untouched
    pulses(5, 1, "R6 prefill");
    step(1, 1, 1, 0, 1, {16'((4 - 11 - 1) & 16'hFFFF), 16'd4}, "R6 write with pulse");
    pulses(6, 0, "R6 after clear");
    step(1, 1, 1, 1, 0, 32'h0000_0000, "R8 write ch1");
    pulses(20, 0, "R8 ch0 continues");

    // R5: inc strobes over mod pulses
    set_rate(0, 4, 11, "R5 setup");
    drain();
    tick0_cnt = 0;
    pulses(11, 1, "R5 window");
    pulses(2, 3, "R5 idle");
    drain();
    checks++;
    if (tick0_cnt != 4) begin
      errors++;
      $display("FAIL R5: ticks=%0d over 11 pulses, expected=4", tick0_cnt);
    end

    // R2: select with high bits set but bit0 clear picks 48k
    step(0, 0, 1, 0, 0, 32'hFFFF_FFFE, "R2 high bits ignored");
    pulses(30, 0, "R2 switched master");

    // R3: wrapped term gives mod 65535
    set_rate(1, 4, 65535, "R3 wrap");
    pulses(20, 0, "R3 wrap run");

    pulses(2, 3, "idle");
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule